// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers the FIFO condition flags and the interrupt state of a UART with memory-mapped registers. It looks at the receive and transmit FIFO fill counts and compares them against two trigger thresholds that software can program. From these it forms a live status word, which it rebuilds from scratch every cycle.

Live conditions and one-cycle event pulses (receive overrun, framing error, parity error, receive timeout, modem status change, transmit overrun) are captured into a sticky interrupt status register. Each captured bit stays set until software writes a one to it. An interrupt mask is changed only through two registers: a write-to-set enable register and a write-to-clear disable register. A single level interrupt output is high while any masked sticky bit is set.

The FIFOs, the serial shifters and bus decoding sit outside this block. The block sees a simple write strobe with a byte address and data, and it returns read data combinationally for the address on the bus.

Top module: `uart_irq_status`

## Requirements
- R1: Live status (read at 0x2C) is recomputed every cycle from the counts. Bit0 is set when the RX count is at or above the RX trigger, bit1 when the RX count is zero, and bit2 when the RX count equals the FIFO depth (64).
- R2: In the live status, bit3 is set when the TX count is zero, bit4 when the TX count equals the depth, and bit13 when the TX count is at or above the TX trigger. All other live bits read as zero.
- R3: On every clock edge, live bits 4:0 are ORed into the same bits of the sticky status (read at 0x14). The TX-trigger condition sets sticky bit10. These bits remain set after the condition goes away.
- R4: A one-cycle event pulse sets a sticky bit at the following edge. The bit positions are RX overrun 5, framing 6, parity 7, timeout 8, modem status 9 and TX overrun 12.
- R5: Writing 0x14 clears exactly those sticky bits where the written data has a one. Writing zero changes nothing.
- R6: Writing 0x08 ORs the data into the mask (read at 0x10). Writing 0x0C clears the mask bits where the data has ones. Writes to 0x10 leave the mask unchanged.
- R7: The `irq` output is high exactly when the mask AND the sticky status is nonzero. It follows a register update in the same cycle as that update.
- R8: While reset is asserted, mask and sticky status are zero, both trigger registers (0x20 RX, 0x44 TX) read 0x20, and `irq` is low.
- R9: When an event, or a live condition, sets a bit in the same cycle that software clears it, the bit ends up set.
- R10: The trigger registers at 0x20 and 0x44 can be written and read back, and they move the comparison thresholds of R1 and R2.
- R11: Only bits 0 to 10 and bit 12 exist in the mask and sticky status, so setting all mask bits reads back 0x17FF. Unmapped addresses, and the write-only enable and disable registers, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rx_count | input | 7 | RX FIFO occupancy |
| tx_count | input | 7 | TX FIFO occupancy |
| ev_rx_ovr | input | 1 | RX overrun event pulse |
| ev_frame | input | 1 | Framing error event pulse |
| ev_parity | input | 1 | Parity error event pulse |
| ev_timeout | input | 1 | Receive timeout event pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_ovr | input | 1 | TX overrun event pulse |
| irq | output | 1 | Level interrupt |

## Verification
A wrong threshold comparison or a misplaced bit shows up at once on the live status read, with no clock needed. A sticky register that fails to capture an event, or clears too much, is visible on the status read one edge after the pulse or write. A mask or sticky state that is wrong reaches `irq` in the same cycle the register settles, so driving the enable, disable and clear writes in sequence exposes it within one clock. The same-cycle collision between an event and a software clear is driven on purpose, because a set-versus-clear priority fault can only be seen in that cycle.

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int ADDR_W     = 8,
  parameter int TRIG_RST   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              ev_rx_ovr,
  input  logic              ev_frame,
  input  logic              ev_parity,
  input  logic              ev_timeout,
  input  logic              ev_modem,
  input  logic              ev_tx_ovr,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_IDIS  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_STKY  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_RXTRG = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_TXTRG = ADDR_W'(8'h44);
  localparam logic [31:0]       IMPL    = 32'h0000_17FF;
  localparam logic [CNT_W-1:0]  FULL    = CNT_W'(FIFO_DEPTH);
  localparam logic [CNT_W-1:0]  TRG0    = CNT_W'(TRIG_RST);

  logic [31:0]      mask_q, sticky_q, live, set_vec, clr_vec;
  logic [CNT_W-1:0] rx_trig_q, tx_trig_q;
  logic             tx_trig_hit;

  wire wr_ien   = reg_wr && (reg_addr == A_IEN);
  wire wr_idis  = reg_wr && (reg_addr == A_IDIS);
  wire wr_stky  = reg_wr && (reg_addr == A_STKY);
  wire wr_rxtrg = reg_wr && (reg_addr == A_RXTRG);
  wire wr_txtrg = reg_wr && (reg_addr == A_TXTRG);

  assign tx_trig_hit = tx_count >= tx_trig_q;

  always_comb begin
    live     = '0;
    live[0]  = rx_count >= rx_trig_q;
    live[1]  = rx_count == '0;
    live[2]  = rx_count == FULL;
    live[3]  = tx_count == '0;
    live[4]  = tx_count == FULL;
    live[13] = tx_trig_hit;
  end

  always_comb begin
    set_vec      = '0;
    set_vec[4:0] = live[4:0];
    set_vec[5]   = ev_rx_ovr;
    set_vec[6]   = ev_frame;
    set_vec[7]   = ev_parity;
    set_vec[8]   = ev_timeout;
    set_vec[9]   = ev_modem;
    set_vec[10]  = tx_trig_hit;
    set_vec[12]  = ev_tx_ovr;
  end

  assign clr_vec = wr_stky ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else begin
      sticky_q <= ((sticky_q & ~clr_vec) | set_vec) & IMPL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_ien) begin
      mask_q <= (mask_q | reg_wdata) & IMPL;
    end else if (wr_idis) begin
      mask_q <= mask_q & ~reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig_q <= TRG0;
      tx_trig_q <= TRG0;
    end else begin
      if (wr_rxtrg) rx_trig_q <= reg_wdata[CNT_W-1:0];
      if (wr_txtrg) tx_trig_q <= reg_wdata[CNT_W-1:0];
    end
  end

  assign irq = |(mask_q & sticky_q);

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = mask_q;
      A_STKY:  reg_rdata = sticky_q;
      A_LIVE:  reg_rdata = live;
      A_RXTRG: reg_rdata = {{(32-CNT_W){1'b0}}, rx_trig_q};
      A_TXTRG: reg_rdata = {{(32-CNT_W){1'b0}}, tx_trig_q};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
  parameter int CNT_W  = 7,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [CNT_W-1:0]  rx_count,
  input logic [CNT_W-1:0]  tx_count,
  input logic              ev_frame,
  input logic [31:0]       sticky_q,
  input logic [31:0]       mask_q,
  input logic [CNT_W-1:0]  tx_trig_q
);

  assert_event_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> sticky_q[6]);

  assert_clear_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(8'h14) && reg_wdata[6] && !ev_frame) |=> !sticky_q[6]);

  assert_mask_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(8'h10)) |=> $stable(mask_q));

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(8'h08) && reg_wdata[6]) |=> mask_q[6]);

  assert_rx_empty_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> sticky_q[1]);

  assert_tx_trig_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count >= tx_trig_q) |=> sticky_q[10]);

endmodule

bind uart_irq_status uart_irq_status_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .rx_count(rx_count), .tx_count(tx_count),
  .ev_frame(ev_frame), .sticky_q(sticky_q), .mask_q(mask_q),
  .tx_trig_q(tx_trig_q)
);

// File: tb/uart_irq_status_bench.sv
module uart_irq_status_bench;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [6:0]  rx_count = 7'd10, tx_count = 7'd31;
  logic ev_rx_ovr = 0, ev_frame = 0, ev_parity = 0, ev_timeout = 0, ev_modem = 0, ev_tx_ovr = 0;
  logic irq;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  uart_irq_status u_uart_irq_status (.*);

  // {rx, tx, expected live status} with default triggers of 32
  localparam logic [45:0] VEC [8] = '{
    {7'd0,  7'd0,  32'h0000_000A},
    {7'd31, 7'd0,  32'h0000_0008},
    {7'd32, 7'd0,  32'h0000_0009},
    {7'd64, 7'd0,  32'h0000_000D},
    {7'd0,  7'd32, 32'h0000_2002},
    {7'd0,  7'd64, 32'h0000_2012},
    {7'd10, 7'd31, 32'h0000_0000},
    {7'd63, 7'd63, 32'h0000_2001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick; reg_wr = 0; reg_wdata = 0;
  endtask

  initial begin
    logic [31:0] d;
    #5;
    rd(8'h14, d); chk("R8 sticky", d, 0);
    rd(8'h10, d); chk("R8 mask", d, 0);
    rd(8'h20, d); chk("R8 rxtrig", d, 32'h20);
    rd(8'h44, d); chk("R8 txtrig", d, 32'h20);
    chk("R8 irq", {31'd0, irq}, 0);
    rst_n = 1; tick;

    for (int i = 0; i < 8; i++) begin
      rx_count = VEC[i][45:39]; tx_count = VEC[i][38:32];
      rd(8'h2C, d); chk("R1 R2 live", d, VEC[i][31:0]);
    end

    rx_count = 10; tx_count = 31; tick;
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, d); chk("R5 clear all", d, 0);
    tx_count = 40; tick; rd(8'h14, d); chk("R3 txtrig bit10", d, 32'h400);
    tx_count = 31; tick; rd(8'h14, d); chk("R3 persists", d, 32'h400);
    wr(8'h14, 32'h400);
    rx_count = 0; tick; rd(8'h14, d); chk("R3 rx empty", d, 32'h2);
    rx_count = 10; wr(8'h14, 32'h2); rd(8'h14, d); chk("R5 clear bit1", d, 0);

    ev_rx_ovr = 1;  tick; ev_rx_ovr = 0;  rd(8'h14, d); chk("R4 rx ovr", d, 32'h20);
    ev_frame = 1;   tick; ev_frame = 0;   rd(8'h14, d); chk("R4 frame", d, 32'h60);
    ev_parity = 1;  tick; ev_parity = 0;  rd(8'h14, d); chk("R4 parity", d, 32'hE0);
    ev_timeout = 1; tick; ev_timeout = 0; rd(8'h14, d); chk("R4 timeout", d, 32'h1E0);
    ev_modem = 1;   tick; ev_modem = 0;   rd(8'h14, d); chk("R4 modem", d, 32'h3E0);
    ev_tx_ovr = 1;  tick; ev_tx_ovr = 0;  rd(8'h14, d); chk("R4 tx ovr", d, 32'h13E0);
    wr(8'h14, 32'h60); rd(8'h14, d); chk("R5 selective", d, 32'h1380);
    wr(8'h14, 32'h0);  rd(8'h14, d); chk("R5 zero write", d, 32'h1380);

    chk("R7 irq masked off", {31'd0, irq}, 0);
    wr(8'h08, 32'h100); rd(8'h10, d); chk("R6 enable", d, 32'h100);
    chk("R7 irq high", {31'd0, irq}, 1);
    wr(8'h10, 32'h0); rd(8'h10, d); chk("R6 mask write ignored", d, 32'h100);
    wr(8'h0C, 32'h100); rd(8'h10, d); chk("R6 disable", d, 0);
    chk("R7 irq low", {31'd0, irq}, 0);
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h10, d); chk("R11 mask bits", d, 32'h17FF);
    chk("R7 irq all", {31'd0, irq}, 1);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R11 enable reads zero", d, 0);

    wr(8'h14, 32'hFFFF_FFFF);
    ev_parity = 1; wr(8'h14, 32'h80); ev_parity = 0;
    rd(8'h14, d); chk("R9 set wins", d, 32'h80);
    wr(8'h14, 32'h80);

    wr(8'h08, 32'h2); rx_count = 0; #1;
    chk("R7 before edge", {31'd0, irq}, 0);
    tick; chk("R7 after edge", {31'd0, irq}, 1);
    rx_count = 10; wr(8'h14, 32'h2);
    chk("R7 cleared", {31'd0, irq}, 0);
    wr(8'h0C, 32'h2);

    wr(8'h20, 32'h5); rd(8'h20, d); chk("R10 rxtrig read", d, 32'h5);
    rx_count = 5; rd(8'h2C, d); chk("R10 rx at trig", d, 32'h1);
    rx_count = 4; rd(8'h2C, d); chk("R10 rx below", d, 32'h0);
    wr(8'h44, 32'h3); rd(8'h2C, d); chk("R10 tx trig", d, 32'h2000);
    rd(8'h30, d); chk("R11 unmapped", d, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule